// File: doc/BRIEF.md
# Banked Three-Port Register File

This block holds the general registers of a small soft processor core. Each instruction names up to three registers: two sources and one destination. Each name is a 4-bit field, so one instruction can reach only 16 registers. The storage holds twice that many. A mode flag inside the block adds the top address bit. In normal mode, every access lands in the lower 16 physical registers. In interrupt mode, every access lands in the upper 16. A handler can therefore use any register without saving the main program's state.

There are two combinational read ports and one clocked write port. Each read port is served by its own copy of a single-read store, and every write is applied to all copies. Each copy is organised as rows of register pairs. A 32-bit value kept in an even/odd pair can be read whole on a pair output. The single 16-bit output returns the half picked by the low bit of the field. Reads show the stored contents only, so a read of the register being written returns the old value until the edge.

Top module: `banked_regfile`

## Requirements
- R1: When wr_en is high at a rising clock edge, the addressed register takes wr_data. When wr_en is low, no register changes.
- R2: Each read port returns, combinationally and independently of the other, the current contents of the register its field names.
- R3: The physical register index is {mode, field}. Mode 0 reaches physical registers 0..15 and mode 1 reaches 16..31, for both reads and writes.
- R4: Writes made in one mode never change any register seen in the other mode.
- R5: The mode flag takes mode_val at a rising edge where mode_load is high, and otherwise holds. Reset clears it to 0 (normal bank).
- R6: rd_pair_x is {register (field with bit0=1), register (field with bit0=0)} of the current bank, with the odd register in bits 31:16. rd_data_x equals bits 15:0 of rd_pair_x when field bit0 is 0, and bits 31:16 when it is 1.
- R7: A read of the register being written in the same cycle returns the old value. The new value appears only after the edge.
- R8: Register 0 of each bank stores and returns data like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; clears the mode flag |
| mode_load | input | 1 | Load strobe for the mode flag |
| mode_val | input | 1 | New mode: 0 normal bank, 1 interrupt bank |
| wr_en | input | 1 | Write enable |
| wr_field | input | 4 | Destination register field |
| wr_data | input | 16 | Write data |
| rd_field_a | input | 4 | Source field, port A |
| rd_field_b | input | 4 | Source field, port B |
| rd_data_a | output | 16 | Selected half, port A |
| rd_data_b | output | 16 | Selected half, port B |
| rd_pair_a | output | 32 | Whole register pair, port A |
| rd_pair_b | output | 32 | Whole register pair, port B |

## Verification
The assertions take for granted that every input is known and settled at each rising edge after reset. They also assume that register contents are only compared once they have been written, since the store has no reset. The stimulus drives all inputs on the falling edge. It writes every register of both banks before any full sweep of reads, and it compares only against registers the bench model has set. Mode changes are made by a single load cycle, with no write or read-check in that cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
   typedef enum logic {
      BANK_MAIN   = 1'b0,
      BANK_SHADOW = 1'b1
   } bank_e;

   localparam int unsigned RF_BANKS = 2;
endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
   import rf_pkg::*;
#(
   parameter int unsigned FIELD_W = 4
) (
   input  bank_e              bank,
   input  logic [FIELD_W-1:0] field,
   output logic [FIELD_W-1:0] row,
   output logic               half
);
   logic [FIELD_W:0] phys;

   always_comb begin
      phys = {bank, field};
      row  = phys[FIELD_W:1];
      half = phys[0];
   end
endmodule

// File: rtl/rf_pair_mem.sv
module rf_pair_mem #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ROW_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [ROW_W-1:0]    wr_row,
   input  logic                wr_half,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [ROW_W-1:0]    rd_row,
   output logic [2*DATA_W-1:0] rd_word
);
   localparam int unsigned ROWS = 1 << ROW_W;

   logic [DATA_W-1:0] lo_q [ROWS];
   logic [DATA_W-1:0] hi_q [ROWS];

   always_ff @(posedge clk) begin
      if (we) begin
         if (wr_half) hi_q[wr_row] <= wdata;
         else         lo_q[wr_row] <= wdata;
      end
   end

   assign rd_word = {hi_q[rd_row], lo_q[rd_row]};

   // R1: with no write and a steady row, the row read out must not move
   a_r1_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && rd_row == $past(rd_row) && !$past(we)) |-> $stable(rd_word));

   // R1/R7: a row read just after a write of that row shows the new half
   a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && rd_row == wr_row) |=>
         (rd_row != $past(rd_row)) ||
         (($past(wr_half) ? rd_word[2*DATA_W-1:DATA_W] : rd_word[DATA_W-1:0]) == $past(wdata)));
endmodule

// File: rtl/rf_half_sel.sv
module rf_half_sel #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [2*DATA_W-1:0] word,
   input  logic                half,
   output logic [DATA_W-1:0]   data
);
   always_comb begin
      if (half) data = word[2*DATA_W-1:DATA_W];
      else      data = word[DATA_W-1:0];
   end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import rf_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned FIELD_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_load,
   input  logic                mode_val,
   input  logic                wr_en,
   input  logic [FIELD_W-1:0]  wr_field,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [FIELD_W-1:0]  rd_field_a,
   input  logic [FIELD_W-1:0]  rd_field_b,
   output logic [DATA_W-1:0]   rd_data_a,
   output logic [DATA_W-1:0]   rd_data_b,
   output logic [2*DATA_W-1:0] rd_pair_a,
   output logic [2*DATA_W-1:0] rd_pair_b
);
   localparam int unsigned RD_PORTS = 2;
   localparam int unsigned ROW_W    = FIELD_W;

   if (DATA_W < 1)  begin : g_bad_width  $error("DATA_W must be at least 1");  end
   if (FIELD_W < 1) begin : g_bad_field  $error("FIELD_W must be at least 1"); end
   if (RF_BANKS != 2) begin : g_bad_bank $error("bank mapping assumes two banks"); end

   bank_e bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bank_q <= BANK_MAIN;
      else if (mode_load) bank_q <= bank_e'(mode_val);
   end

   logic [ROW_W-1:0] wr_row;
   logic             wr_half;

   rf_bank_map #(.FIELD_W(FIELD_W)) u_wmap (
      .bank(bank_q), .field(wr_field), .row(wr_row), .half(wr_half)
   );

   logic [FIELD_W-1:0]  rd_field [RD_PORTS];
   logic [ROW_W-1:0]    rd_row   [RD_PORTS];
   logic                rd_half  [RD_PORTS];
   logic [2*DATA_W-1:0] rd_word  [RD_PORTS];
   logic [DATA_W-1:0]   rd_data  [RD_PORTS];

   assign rd_field[0] = rd_field_a;
   assign rd_field[1] = rd_field_b;

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
      rf_bank_map #(.FIELD_W(FIELD_W)) u_rmap (
         .bank(bank_q), .field(rd_field[p]), .row(rd_row[p]), .half(rd_half[p])
      );

      rf_pair_mem #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_copy (
         .clk(clk), .rst_n(rst_n), .we(wr_en), .wr_row(wr_row), .wr_half(wr_half),
         .wdata(wr_data), .rd_row(rd_row[p]), .rd_word(rd_word[p])
      );

      rf_half_sel #(.DATA_W(DATA_W)) u_sel (
         .word(rd_word[p]), .half(rd_half[p]), .data(rd_data[p])
      );
   end

   assign rd_data_a = rd_data[0];
   assign rd_data_b = rd_data[1];
   assign rd_pair_a = rd_word[0];
   assign rd_pair_b = rd_word[1];

   // R5: the mode flag moves only on a load cycle
   a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_load |=> $stable(bank_q));

   // R2: both copies receive every write, so equal fields give equal pairs
   a_r2_copies_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_field_a == rd_field_b && $past(wr_en)) |-> rd_pair_a == rd_pair_b);

   // R6: the half output of port A matches the half of its pair picked by bit 0
   a_r6_half_of_pair: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_a == (rd_field_a[0] ? rd_pair_a[2*DATA_W-1:DATA_W] : rd_pair_a[DATA_W-1:0]));

   // R6: same for port B
   a_r6_half_of_pair_b: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_b == (rd_field_b[0] ? rd_pair_b[2*DATA_W-1:DATA_W] : rd_pair_b[DATA_W-1:0]));
endmodule

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_load = 1'b0, mode_val = 1'b0, wr_en = 1'b0;
   logic [3:0]  wr_field = '0, rd_field_a = '0, rd_field_b = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data_a, rd_data_b;
   logic [31:0] rd_pair_a, rd_pair_b;

   int checks = 0;
   int errors = 0;
   logic        bank = 1'b0;
   logic [15:0] model [32];

   always #4 clk = ~clk;

   banked_regfile u0 (
      .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_val(mode_val),
      .wr_en(wr_en), .wr_field(wr_field), .wr_data(wr_data),
      .rd_field_a(rd_field_a), .rd_field_b(rd_field_b),
      .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
      .rd_pair_a(rd_pair_a), .rd_pair_b(rd_pair_b)
   );

   function automatic logic [15:0] pat(input int b, input int f, input int pass);
      return 16'(b * 16'h4000 + f * 16'h0101 + pass * 16'h0013 + 16'h0007);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_mode(input logic v);
      @(negedge clk); mode_load = 1'b1; mode_val = v;
      @(negedge clk); mode_load = 1'b0; mode_val = ~v;
      bank = v;
   endtask

   task automatic do_write(input logic [3:0] f, input logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; wr_field = f; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
      model[{bank, f}] = d;
   endtask

   task automatic read_check(input logic [3:0] fa, input logic [3:0] fb, input string req);
      @(negedge clk); rd_field_a = fa; rd_field_b = fb; #1;
      chk(req, {16'h0, rd_data_a}, {16'h0, model[{bank, fa}]});
      chk(req, {16'h0, rd_data_b}, {16'h0, model[{bank, fb}]});
      chk(req, rd_pair_a, {model[{bank, fa[3:1], 1'b1}], model[{bank, fa[3:1], 1'b0}]});
      chk(req, rd_pair_b, {model[{bank, fb[3:1], 1'b1}], model[{bank, fb[3:1], 1'b0}]});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R5 reset state: first write after reset must land in the normal bank
      do_write(4'd3, 16'h1234);
      set_mode(1'b1);
      do_write(4'd3, 16'h5678);
      set_mode(1'b0);
      @(negedge clk); rd_field_a = 4'd3; #1;
      chk("R5 reset mode main", {16'h0, rd_data_a}, 32'h1234);
      set_mode(1'b1);
      @(negedge clk); rd_field_a = 4'd3; #1;
      chk("R3 shadow reg3", {16'h0, rd_data_a}, 32'h5678);

      // fill both banks (R1, R3, R8 via field 0)
      for (int b = 0; b < 2; b++) begin
         set_mode(b[0]);
         for (int f = 0; f < 16; f++) do_write(4'(f), pat(b, f, 0));
      end
      for (int b = 0; b < 2; b++) begin
         set_mode(b[0]);
         for (int f = 0; f < 16; f++) read_check(4'(f), 4'(15 - f), "R2 R3 R6 sweep");
      end
      set_mode(1'b0);
      @(negedge clk); rd_field_a = 4'd0; #1;
      chk("R8 reg0 main", {16'h0, rd_data_a}, {16'h0, pat(0, 0, 0)});
      set_mode(1'b1);
      @(negedge clk); rd_field_a = 4'd0; #1;
      chk("R8 reg0 shadow", {16'h0, rd_data_a}, {16'h0, pat(1, 0, 0)});

      // R4: rewrite the main bank, shadow must be unchanged
      set_mode(1'b0);
      for (int f = 0; f < 16; f++) do_write(4'(f), pat(0, f, 1));
      set_mode(1'b1);
      for (int f = 0; f < 16; f++) read_check(4'(f), 4'(f ^ 1), "R4 shadow kept");
      set_mode(1'b0);
      for (int f = 0; f < 16; f++) read_check(4'(f), 4'(f), "R4 main rewritten");

      // R1: no write when wr_en is low
      @(negedge clk); wr_en = 1'b0; wr_field = 4'd6; wr_data = 16'hDEAD; rd_field_a = 4'd6;
      @(negedge clk); #1;
      chk("R1 no write", {16'h0, rd_data_a}, {16'h0, model[6]});

      // R7: read during write returns old, new after the edge
      @(negedge clk); wr_en = 1'b1; wr_field = 4'd9; wr_data = 16'hBEEF;
      rd_field_a = 4'd9; rd_field_b = 4'd8; #1;
      chk("R7 old value", {16'h0, rd_data_a}, {16'h0, model[9]});
      chk("R7 pair old", rd_pair_b, {model[9], model[8]});
      @(posedge clk); #1;
      chk("R7 new value", {16'h0, rd_data_a}, 32'hBEEF);
      chk("R6 pair new", rd_pair_b, {16'hBEEF, model[8]});
      @(negedge clk); wr_en = 1'b0;
      model[9] = 16'hBEEF;

      // R5: mode holds without a load strobe
      @(negedge clk); mode_val = 1'b1; rd_field_a = 4'd9;
      @(negedge clk); #1;
      chk("R5 mode hold", {16'h0, rd_data_a}, 32'hBEEF);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule